// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, called A and B, and can carry data in either direction between them. Each side has its own storage register with its own capture clock. A rising edge on a side's clock always stores that side's bus value. Capture does not depend on the output controls.

An active-low enable gates the output drivers. A direction input picks which bus is driven. For each direction, a select input chooses what the driven bus carries: either the live value of the opposite bus, passed through with no register, or the stored register of the opposite side. The pins are modelled as separate input, output and output-enable ports, so the block can be placed inside a larger synthesizable design. Outside logic merges these ports into real pads.

An active-low asynchronous reset clears both registers to zero.

Top module: `bus_xcvr_top`

## Requirements
- R1: While `rst_n` is low, both storage registers are zero. A stored-mode output read right after reset is 8'h00.
- R2: On every rising edge of `a_cap_clk`, the A-side register takes the value of `a_in`, whatever the values of `oe_n`, `dir_to_b` and the selects.
- R3: On every rising edge of `b_cap_clk`, the B-side register takes the value of `b_in`, whatever the values of `oe_n`, `dir_to_b` and the selects.
- R4: While `oe_n` is 1, `a_oe` and `b_oe` are both 0, and `a_out` and `b_out` are both 8'h00.
- R5: While `oe_n` is 0, `dir_to_b`=1 gives `b_oe`=1 and `a_oe`=0, and `dir_to_b`=0 gives `a_oe`=1 and `b_oe`=0.
- R6: When B is driven and `sel_a_stored`=0, `b_out` equals `a_in` with no clock involved.
- R7: When B is driven and `sel_a_stored`=1, `b_out` equals the A-side register.
- R8: When A is driven and `sel_b_stored`=0, `a_out` equals `b_in` with no clock involved.
- R9: When A is driven and `sel_b_stored`=1, `a_out` equals the B-side register.
- R10: In stored mode, a rising edge on the source-side capture clock puts the newly captured value on the opposite output in the same edge. No further edge is needed.
- R11: The select that belongs to the inactive direction has no effect on either output.
- R12: `a_oe` and `b_oe` are never 1 at the same time.
- R13: An output whose enable is 0 reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous clear of both registers |
| a_cap_clk | input | 1 | Rising edge stores `a_in` into the A-side register |
| b_cap_clk | input | 1 | Rising edge stores `b_in` into the B-side register |
| oe_n | input | 1 | Active-low output enable for both buses |
| dir_to_b | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_a_stored | input | 1 | 1: B carries the A register; 0: B carries live `a_in` |
| sel_b_stored | input | 1 | 1: A carries the B register; 0: A carries live `b_in` |
| a_in | input | 8 | Value seen on the A bus |
| a_out | output | 8 | Value driven onto the A bus |
| a_oe | output | 1 | A bus driver enable |
| b_in | input | 8 | Value seen on the B bus |
| b_out | output | 8 | Value driven onto the B bus |
| b_oe | output | 1 | B bus driver enable |

## Verification
Two functions can fall on one edge: capturing into a side's register, and presenting that same register on the opposite bus in stored mode. The bench provokes this by changing the source bus, raising its capture clock while stored mode is selected, and then reading the opposite output just after the edge. The output must already show the new word. A second collision is capture while the outputs are isolated. The bench judges it by re-enabling the outputs in stored mode, with no further clock edge, and reading back the word captured during isolation.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

    typedef enum logic {
        DRIVE_A = 1'b0,
        DRIVE_B = 1'b1
    } drive_dir_e;

    typedef enum logic {
        PICK_LIVE   = 1'b0,
        PICK_STORED = 1'b1
    } path_pick_e;

endpackage

// File: rtl/bus_xcvr_store.sv
module bus_xcvr_store #(
    parameter int WIDTH = 8
) (
    input  logic             rst_n,
    input  logic             cap_clk,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] held
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } store_t;

    store_t st_d;
    store_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.word = bus_in;
    end

    always_ff @(posedge cap_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.word;

    // R2 R3
    capture_chk: assert property (@(posedge cap_clk) disable iff (!rst_n)
        rst_n |=> (held == $past(bus_in)))
        else $error("store register missed capture");

endmodule

// File: rtl/bus_xcvr_dir.sv
module bus_xcvr_dir
    import bus_xcvr_pkg::*;
(
    input  logic rst_n,
    input  logic oe_n,
    input  logic dir_to_b,
    output logic a_oe,
    output logic b_oe
);

    drive_dir_e dir_e;

    always_comb begin
        dir_e = drive_dir_e'(dir_to_b);
        a_oe  = 1'b0;
        b_oe  = 1'b0;
        if (!oe_n) begin
            case (dir_e)
                DRIVE_B: b_oe = 1'b1;
                default: a_oe = 1'b1;
            endcase
        end
    end

    always_comb begin
        if (rst_n) begin
            // R12
            oe_excl_chk: assert (!(a_oe && b_oe))
                else $error("both bus enables asserted");
            // R4
            isolate_chk: assert (!oe_n || (!a_oe && !b_oe))
                else $error("enable asserted while isolated");
        end
    end

endmodule

// File: rtl/bus_xcvr_path.sv
module bus_xcvr_path
    import bus_xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             drive_en,
    input  logic             pick_stored,
    input  logic [WIDTH-1:0] live_word,
    input  logic [WIDTH-1:0] stored_word,
    output logic [WIDTH-1:0] out_word
);

    path_pick_e pick_e;

    always_comb begin
        pick_e   = path_pick_e'(pick_stored);
        out_word = '0;
        if (drive_en) begin
            case (pick_e)
                PICK_STORED: out_word = stored_word;
                default:     out_word = live_word;
            endcase
        end
    end

endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top #(
    parameter int WIDTH = 8
) (
    input  logic             rst_n,
    input  logic             a_cap_clk,
    input  logic             b_cap_clk,
    input  logic             oe_n,
    input  logic             dir_to_b,
    input  logic             sel_a_stored,
    input  logic             sel_b_stored,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);

    localparam int SIDES = 2;

    logic [SIDES-1:0]            side_clk;
    logic [SIDES-1:0][WIDTH-1:0] side_in;
    logic [SIDES-1:0][WIDTH-1:0] side_held;

    assign side_clk = {b_cap_clk, a_cap_clk};
    assign side_in  = {b_in, a_in};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        bus_xcvr_store #(.WIDTH(WIDTH)) u_store (
            .rst_n   (rst_n),
            .cap_clk (side_clk[s]),
            .bus_in  (side_in[s]),
            .held    (side_held[s])
        );
    end

    bus_xcvr_dir u_dir (
        .rst_n    (rst_n),
        .oe_n     (oe_n),
        .dir_to_b (dir_to_b),
        .a_oe     (a_oe),
        .b_oe     (b_oe)
    );

    bus_xcvr_path #(.WIDTH(WIDTH)) u_to_b (
        .drive_en    (b_oe),
        .pick_stored (sel_a_stored),
        .live_word   (a_in),
        .stored_word (side_held[0]),
        .out_word    (b_out)
    );

    bus_xcvr_path #(.WIDTH(WIDTH)) u_to_a (
        .drive_en    (a_oe),
        .pick_stored (sel_b_stored),
        .live_word   (b_in),
        .stored_word (side_held[1]),
        .out_word    (a_out)
    );

    always_comb begin
        if (rst_n) begin
            // R6
            live_to_b_chk: assert (!(b_oe && !sel_a_stored) || (b_out == a_in))
                else $error("live A path not on B");
            // R8
            live_to_a_chk: assert (!(a_oe && !sel_b_stored) || (a_out == b_in))
                else $error("live B path not on A");
            // R13
            idle_zero_chk: assert ((a_oe || a_out == '0) && (b_oe || b_out == '0))
                else $error("undriven output not zero");
        end
    end

endmodule

// File: tb/bus_xcvr_top_bench.sv
module bus_xcvr_top_bench;

    logic       clk = 1'b0;
    logic       rst_n, a_cap_clk, b_cap_clk, oe_n, dir_to_b;
    logic       sel_a_stored, sel_b_stored;
    logic [7:0] a_in, b_in, a_out, b_out;
    logic       a_oe, b_oe;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    bus_xcvr_top u_bus_xcvr_top (
        .rst_n(rst_n), .a_cap_clk(a_cap_clk), .b_cap_clk(b_cap_clk),
        .oe_n(oe_n), .dir_to_b(dir_to_b),
        .sel_a_stored(sel_a_stored), .sel_b_stored(sel_b_stored),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic setup(logic o, logic d, logic sa, logic sb, logic [7:0] av, logic [7:0] bv);
        @(negedge clk);
        oe_n = o; dir_to_b = d; sel_a_stored = sa; sel_b_stored = sb;
        a_in = av; b_in = bv;
        #1;
    endtask

    task automatic pulse_a();
        @(negedge clk); a_cap_clk = 1'b1; #1;
    endtask

    task automatic pulse_b();
        @(negedge clk); b_cap_clk = 1'b1; #1;
    endtask

    task automatic release_clks();
        @(negedge clk); a_cap_clk = 1'b0; b_cap_clk = 1'b0;
    endtask

    task automatic t_reset();
        setup(1'b0, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hC3);
        check("R1 A reg after reset", b_out, 8'h00);
        setup(1'b0, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hC3);
        check("R1 B reg after reset", a_out, 8'h00);
    endtask

    task automatic t_isolation();
        setup(1'b1, 1'b1, 1'b0, 1'b0, 8'hA5, 8'h3C);
        check("R4 a_oe", {7'b0, a_oe}, 8'h00);
        check("R4 b_oe", {7'b0, b_oe}, 8'h00);
        check("R4 a_out", a_out, 8'h00);
        check("R4 b_out", b_out, 8'h00);
        setup(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C);
        check("R12 isolated oe", {6'b0, a_oe, b_oe}, 8'h00);
    endtask

    task automatic t_live();
        setup(1'b0, 1'b1, 1'b0, 1'b0, 8'h12, 8'h99);
        check("R5 b_oe", {6'b0, a_oe, b_oe}, 8'h01);
        check("R6 live A to B", b_out, 8'h12);
        check("R13 A idle", a_out, 8'h00);
        setup(1'b0, 1'b1, 1'b0, 1'b0, 8'hE7, 8'h99);
        check("R6 live A to B second", b_out, 8'hE7);
        setup(1'b0, 1'b0, 1'b0, 1'b0, 8'h12, 8'h4D);
        check("R5 a_oe", {6'b0, a_oe, b_oe}, 8'h02);
        check("R8 live B to A", a_out, 8'h4D);
        check("R13 B idle", b_out, 8'h00);
    endtask

    task automatic t_stored();
        setup(1'b0, 1'b1, 1'b1, 1'b0, 8'h6B, 8'h00);
        pulse_a();
        check("R10 A capture shown on B", b_out, 8'h6B);
        release_clks();
        setup(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h00);
        check("R7 B holds A reg", b_out, 8'h6B);
        setup(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h81);
        pulse_b();
        check("R10 B capture shown on A", a_out, 8'h81);
        release_clks();
        setup(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h7E);
        check("R9 A holds B reg", a_out, 8'h81);
    endtask

    task automatic t_capture_isolated();
        setup(1'b1, 1'b0, 1'b0, 1'b0, 8'h2C, 8'hD4);
        pulse_a(); release_clks();
        pulse_b(); release_clks();
        setup(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        check("R2 A captured while isolated", b_out, 8'h2C);
        setup(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
        check("R3 B captured while isolated", a_out, 8'hD4);
        setup(1'b0, 1'b0, 1'b0, 1'b1, 8'h37, 8'h00);
        pulse_a(); release_clks();
        setup(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        check("R2 A captured while driving A", b_out, 8'h37);
    endtask

    task automatic t_other_select();
        setup(1'b0, 1'b1, 1'b0, 1'b0, 8'h55, 8'hAA);
        check("R11 sb=0 B out", b_out, 8'h55);
        setup(1'b0, 1'b1, 1'b0, 1'b1, 8'h55, 8'hAA);
        check("R11 sb=1 B out", b_out, 8'h55);
        check("R11 sb=1 A idle", a_out, 8'h00);
        setup(1'b0, 1'b0, 1'b1, 1'b0, 8'h55, 8'hAA);
        check("R11 sa=1 A out", a_out, 8'hAA);
        check("R11 sa=1 B idle", b_out, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; a_cap_clk = 1'b0; b_cap_clk = 1'b0;
        oe_n = 1'b1; dir_to_b = 1'b0; sel_a_stored = 1'b0; sel_b_stored = 1'b0;
        a_in = '0; b_in = '0;
        repeat (3) @(posedge clk);
        pulse_a(); release_clks();
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_isolation();
        t_live();
        t_stored();
        t_capture_isolated();
        t_other_select();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule